// File: doc/BRIEF.md
# Capture-Compare Timestamp Timer

The block keeps a free-running timestamp count that, while enabled, advances by a programmable step on every clock. It has one capture channel and one compare channel. The capture channel watches an asynchronous latch input. The block synchronises that input and detects its rising edge inside. On each accepted edge it stores the current count, raises a capture flag and pulses an event output for one cycle. Software reads the stored value, and that read clears the flag. The compare channel checks the count against a programmed value. On a match it raises a sticky flag, and it can also send the count back to zero.

Software reaches every setting through a word-addressed register port. Every request is taken in the cycle it is presented, and there is no back-pressure, so no ready signal exists. A read returns its data with a one-cycle `rsp_valid` strobe on the next clock edge. Writes return no response. To count external pulses, software polls the capture flag, or it watches `cap_evt`.

Register words (addresses on `req_addr`):
- 0, control: bit 0 enables counting, bits [INC_W+3:4] hold the step.
- 1, count.
- 2, compare setup: bit 0 enables compare, bit 1 sends the count to zero on a match.
- 3, compare value.
- 4, compare flag in bit 0. Writing 1 clears it.
- 5, captured value.
- 6, capture flag in bit 0.
- 7, capture setup: bit 0 blocks external capture, bit 1 selects single-shot mode. The value 0 gives continuous capture.

Top module: `cc_tstamp_timer`

## Requirements
- R1: After reset the control word reads 0x10 (disabled, step 1). Count, compare setup, compare value, both flags, the captured value and the capture setup all read 0. `cap_evt` and `rsp_valid` are low.
- R2: A read request with `req_valid`=1 and `req_write`=0 produces `rsp_valid`=1 for exactly one cycle after the next clock edge. `rsp_rdata` carries the word as it was before that edge.
- R3: While enabled, with no compare reset taking effect, the count grows by the step (control bits [INC_W+3:4]) on every clock, modulo 2^CNT_W.
- R4: A write to the count word is taken only while the timer is disabled. While the timer is enabled the write has no effect, and counting continues undisturbed.
- R5: While enabled, with compare setup bits 0 and 1 both set, a count equal to the compare value becomes 0 on the next clock instead of advancing.
- R6: The compare flag sets on any enabled clock where compare is enabled and the count equals the compare value. Writing 1 to bit 0 of word 4 clears it. Writing 0 leaves it unchanged.
- R7: A rising edge on `latch_in` is captured on the third clock edge after it. At that edge the count is stored in word 5, the capture flag sets, and `cap_evt` is high for the one following cycle.
- R8: Reading word 5 clears the capture flag.
- R9: If a capture and a read of word 5 fall on the same edge, the read returns the old value, the new value is stored, and the flag stays set.
- R10: With capture setup 0, every edge re-captures, even while the flag is set. With bit 1 set, edges are ignored while the flag is set. With bit 0 set, all edges are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request present this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 3 | Register word address |
| req_wdata | input | CNT_W | Write data |
| rsp_valid | output | 1 | Read data valid strobe |
| rsp_rdata | output | CNT_W | Read data |
| latch_in | input | 1 | Asynchronous capture trigger |
| cap_evt | output | 1 | One-cycle pulse per capture |

## Verification
The hardest case to reach is a capture and a clearing read of the captured value landing on the same clock edge (R9). The bench stops the count at a known value, raises `latch_in`, and counts two edges into the synchroniser. It then presents the read so that the read is sampled on the capture edge. Constrained random steps, compare values and idle gaps then exercise stepping and wrap against a bench model.

// File: rtl/cc_tstamp_pkg.sv
package cc_tstamp_pkg;
  typedef enum logic [2:0] {
    RG_CTRL    = 3'd0,
    RG_COUNT   = 3'd1,
    RG_CMPCFG  = 3'd2,
    RG_CMPVAL  = 3'd3,
    RG_CMPSTAT = 3'd4,
    RG_CAPVAL  = 3'd5,
    RG_CAPSTAT = 3'd6,
    RG_CAPCFG  = 3'd7
  } reg_addr_e;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_INC_LSB = 4;
  localparam int CMP_EN_BIT   = 0;
  localparam int CMP_RST_BIT  = 1;
  localparam int CAP_DIS_BIT  = 0;
  localparam int CAP_ONE_BIT  = 1;
endpackage

// File: rtl/cc_tstamp_sync.sv
module cc_tstamp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], din};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/cc_tstamp_counter.sv
module cc_tstamp_counter #(
  parameter int CNT_W = 32,
  parameter int INC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [INC_W-1:0] inc,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_val,
  input  logic             cmp_en,
  input  logic             rst_on_hit,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic             cmp_clr,
  output logic [CNT_W-1:0] count,
  output logic             cmp_flag
);
  logic hit;
  assign hit = en & cmp_en & (count == cmp_val);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (en) begin
      if (hit && rst_on_hit) count <= '0;
      else                   count <= count + CNT_W'(inc);
    end else if (wr_en) begin
      count <= wr_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       cmp_flag <= 1'b0;
    else if (hit)     cmp_flag <= 1'b1;
    else if (cmp_clr) cmp_flag <= 1'b0;
  end
endmodule

// File: rtl/cc_tstamp_capture.sv
module cc_tstamp_capture #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  input  logic             ext_dis,
  input  logic             one_shot,
  input  logic [CNT_W-1:0] count,
  input  logic             rd_clr,
  output logic [CNT_W-1:0] cap_val,
  output logic             cap_flag,
  output logic             cap_evt
);
  logic take;
  assign take = rise & ~ext_dis & ~(one_shot & cap_flag);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_val  <= '0;
      cap_flag <= 1'b0;
      cap_evt  <= 1'b0;
    end else begin
      cap_evt <= take;
      if (take) begin
        cap_val  <= count;
        cap_flag <= 1'b1;
      end else if (rd_clr) begin
        cap_flag <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cc_tstamp_timer.sv
module cc_tstamp_timer #(
  parameter int CNT_W       = 32,
  parameter int INC_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [2:0]       req_addr,
  input  logic [CNT_W-1:0] req_wdata,
  output logic             rsp_valid,
  output logic [CNT_W-1:0] rsp_rdata,
  input  logic             latch_in,
  output logic             cap_evt
);
  import cc_tstamp_pkg::*;

  localparam int INC_HI = CTRL_INC_LSB + INC_W - 1;

  logic             en_q;
  logic [INC_W-1:0] inc_q;
  logic             cmp_en_q, cmp_rst_q;
  logic [CNT_W-1:0] cmp_val_q;
  logic             cap_dis_q, cap_one_q;
  logic [CNT_W-1:0] count, cap_val;
  logic             cmp_flag, cap_flag, rise;
  logic             wr, rd;
  reg_addr_e        addr;

  assign addr = reg_addr_e'(req_addr);
  assign wr   = req_valid & req_write;
  assign rd   = req_valid & ~req_write;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      inc_q     <= INC_W'(1);
      cmp_en_q  <= 1'b0;
      cmp_rst_q <= 1'b0;
      cmp_val_q <= '0;
      cap_dis_q <= 1'b0;
      cap_one_q <= 1'b0;
    end else if (wr) begin
      case (addr)
        RG_CTRL: begin
          en_q  <= req_wdata[CTRL_EN_BIT];
          inc_q <= req_wdata[INC_HI:CTRL_INC_LSB];
        end
        RG_CMPCFG: begin
          cmp_en_q  <= req_wdata[CMP_EN_BIT];
          cmp_rst_q <= req_wdata[CMP_RST_BIT];
        end
        RG_CMPVAL: cmp_val_q <= req_wdata;
        RG_CAPCFG: begin
          cap_dis_q <= req_wdata[CAP_DIS_BIT];
          cap_one_q <= req_wdata[CAP_ONE_BIT];
        end
        default: ;
      endcase
    end
  end

  cc_tstamp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(latch_in), .rise(rise)
  );

  cc_tstamp_counter #(.CNT_W(CNT_W), .INC_W(INC_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(en_q), .inc(inc_q),
    .wr_en(wr && addr == RG_COUNT), .wr_val(req_wdata),
    .cmp_en(cmp_en_q), .rst_on_hit(cmp_rst_q), .cmp_val(cmp_val_q),
    .cmp_clr(wr && addr == RG_CMPSTAT && req_wdata[0]),
    .count(count), .cmp_flag(cmp_flag)
  );

  cc_tstamp_capture #(.CNT_W(CNT_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .rise(rise), .ext_dis(cap_dis_q),
    .one_shot(cap_one_q), .count(count),
    .rd_clr(rd && addr == RG_CAPVAL),
    .cap_val(cap_val), .cap_flag(cap_flag), .cap_evt(cap_evt)
  );

  logic [CNT_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (addr)
      RG_CTRL: begin
        rd_mux[CTRL_EN_BIT]         = en_q;
        rd_mux[INC_HI:CTRL_INC_LSB] = inc_q;
      end
      RG_COUNT: rd_mux = count;
      RG_CMPCFG: begin
        rd_mux[CMP_EN_BIT]  = cmp_en_q;
        rd_mux[CMP_RST_BIT] = cmp_rst_q;
      end
      RG_CMPVAL:  rd_mux = cmp_val_q;
      RG_CMPSTAT: rd_mux[0] = cmp_flag;
      RG_CAPVAL:  rd_mux = cap_val;
      RG_CAPSTAT: rd_mux[0] = cap_flag;
      RG_CAPCFG: begin
        rd_mux[CAP_DIS_BIT] = cap_dis_q;
        rd_mux[CAP_ONE_BIT] = cap_one_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd;
      if (rd) rsp_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/cc_tstamp_checker.sv
module cc_tstamp_checker #(
  parameter int CNT_W = 32,
  parameter int INC_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_write,
  input logic             rsp_valid,
  input logic             en_q,
  input logic [INC_W-1:0] inc_q,
  input logic             cmp_en_q,
  input logic             cmp_rst_q,
  input logic [CNT_W-1:0] cmp_val_q,
  input logic [CNT_W-1:0] count,
  input logic             cmp_flag,
  input logic             cap_flag,
  input logic             cap_evt
);
  logic hit;
  assign hit = en_q && cmp_en_q && count == cmp_val_q;

  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid); // R2
  AST_RSP_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid); // R2
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !(hit && cmp_rst_q)) |=> count == $past(count) + CNT_W'($past(inc_q))); // R3
  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && cmp_rst_q) |=> count == '0); // R5
  AST_CMP_SET: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> cmp_flag); // R6
  AST_EVT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |-> cap_flag); // R7
  AST_EVT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> !cap_evt); // R7
endmodule

bind cc_tstamp_timer cc_tstamp_checker #(.CNT_W(CNT_W), .INC_W(INC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .rsp_valid(rsp_valid), .en_q(en_q), .inc_q(inc_q), .cmp_en_q(cmp_en_q),
  .cmp_rst_q(cmp_rst_q), .cmp_val_q(cmp_val_q), .count(count),
  .cmp_flag(cmp_flag), .cap_flag(cap_flag), .cap_evt(cap_evt)
);

// File: tb/sim_cc_tstamp_timer.sv
module sim_cc_tstamp_timer;
  localparam int CW = 32;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, latch_in = 0;
  logic [2:0] req_addr = '0;
  logic [CW-1:0] req_wdata = '0;
  logic rsp_valid, cap_evt;
  logic [CW-1:0] rsp_rdata;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cc_tstamp_timer u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .latch_in(latch_in), .cap_evt(cap_evt)
  );

  task automatic chk(string req, logic [CW-1:0] act, logic [CW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [CW-1:0] d);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(posedge clk); @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [CW-1:0] d);
    req_valid = 1; req_write = 0; req_addr = a;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    d = rsp_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [CW-1:0] model_adv(logic [CW-1:0] v, int n,
      logic [CW-1:0] inc, bit wrap, logic [CW-1:0] c);
    for (int i = 0; i < n; i++) v = (wrap && v == c) ? '0 : v + inc;
    return v;
  endfunction

  function automatic logic [CW-1:0] ctrl_word(bit en, int inc);
    return CW'((inc << 4) | int'(en));
  endfunction

  task automatic pulse_latch();
    latch_in = 1; idle(4); latch_in = 0; idle(4);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] d, a, b, v;
    void'($urandom(32'h5eed));
    idle(3); rst_n = 1; idle(1);

    // R1 reset state
    chk("R1 cap_evt", CW'(cap_evt), 0);
    chk("R1 rsp_valid", CW'(rsp_valid), 0);
    for (int r = 0; r < 8; r++) begin
      rd(3'(r), d);
      chk("R1 reg", d, (r == 0) ? 32'h10 : 32'h0);
    end
    // R2 response strobe
    rd(3'd0, d);
    chk("R2 valid", CW'(rsp_valid), 1);
    idle(1);
    chk("R2 one cycle", CW'(rsp_valid), 0);

    // R3 random steps
    for (int it = 0; it < 20; it++) begin
      int inc = 1 + int'($urandom_range(14));
      int n = int'($urandom_range(30));
      wr(3'd0, ctrl_word(0, inc));
      wr(3'd1, $urandom);
      wr(3'd0, ctrl_word(1, inc));
      rd(3'd1, a); idle(n); rd(3'd1, b);
      chk("R3 step", b - a, CW'((n + 1) * inc));
    end
    // R3 modulo wrap
    wr(3'd0, ctrl_word(0, 3)); wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd0, ctrl_word(1, 3)); rd(3'd1, a); rd(3'd1, b);
    chk("R3 modulo", b, a + 3);

    // R4 write ignored while enabled
    rd(3'd1, a); wr(3'd1, 32'h1234_5678); rd(3'd1, b);
    chk("R4 ignored", b, a + 6);
    wr(3'd0, ctrl_word(0, 3)); wr(3'd1, 32'h1234_5678); rd(3'd1, b);
    chk("R4 taken", b, 32'h1234_5678);

    // R5/R6 compare reset with random period
    for (int it = 0; it < 8; it++) begin
      int inc = 1 + int'($urandom_range(6));
      logic [CW-1:0] c = CW'(inc * (2 + int'($urandom_range(10))));
      int n = int'($urandom_range(40));
      wr(3'd0, ctrl_word(0, inc)); wr(3'd1, 0);
      wr(3'd3, c); wr(3'd2, 3); wr(3'd4, 1);
      wr(3'd0, ctrl_word(1, inc));
      rd(3'd1, a); idle(n); rd(3'd1, b);
      chk("R5 wrap", b, model_adv(a, n + 1, CW'(inc), 1, c));
      idle(int'(c));
      rd(3'd4, d);
      chk("R6 set", d, 1);
    end
    wr(3'd0, ctrl_word(0, 1)); wr(3'd2, 0);
    wr(3'd4, 0); rd(3'd4, d); chk("R6 write0 keeps", d, 1);
    wr(3'd4, 1); rd(3'd4, d); chk("R6 w1c", d, 0);

    // R7 capture timing and value
    wr(3'd7, 0); wr(3'd1, 32'hA5A5_0001);
    latch_in = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); chk("R7 evt high", CW'(cap_evt), 1);
    @(negedge clk); chk("R7 evt low", CW'(cap_evt), 0);
    latch_in = 0; idle(4);
    rd(3'd6, d); chk("R7 flag", d, 1);
    // R10 continuous re-capture while flag set
    wr(3'd1, 32'hA5A5_0002); pulse_latch();
    rd(3'd5, d); chk("R10 continuous", d, 32'hA5A5_0002);
    // R8 read clears
    rd(3'd6, d); chk("R8 cleared", d, 0);

    // R10 single-shot
    wr(3'd7, 2); wr(3'd1, 32'h0000_0333); pulse_latch();
    wr(3'd1, 32'h0000_0444); pulse_latch();
    rd(3'd5, d); chk("R10 one-shot holds", d, 32'h333);
    // R10 disabled
    wr(3'd7, 1); wr(3'd1, 32'h0000_0555); pulse_latch();
    rd(3'd6, d); chk("R10 disabled flag", d, 0);
    rd(3'd5, d); chk("R10 disabled value", d, 32'h333);

    // R9 capture and clearing read on the same edge
    wr(3'd7, 0); wr(3'd1, 32'h0000_0777);
    latch_in = 1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rd(3'd5, d);
    chk("R9 read old", d, 32'h333);
    latch_in = 0; idle(3);
    rd(3'd6, d); chk("R9 flag kept", d, 1);
    rd(3'd5, d); chk("R9 new value", d, 32'h777);
    rd(3'd6, d); chk("R8 after R9", d, 0);

    // random capture values
    for (int it = 0; it < 6; it++) begin
      v = $urandom;
      wr(3'd1, v); pulse_latch();
      rd(3'd5, d); chk("R7 random capture", d, v);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule